// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge

This block sits at the front of an interrupt controller. It samples eight raw request inputs on every clock and turns them into a request register. Each line has its own trigger selection. An edge line latches a request when its input rises. A level line's request simply tracks the input. The trigger selection lives in a byte-wide register that software can write and read. Bits that the instance does not allow to be level-triggered are forced to zero on write.

When the priority logic picks a line, it pulses the acknowledge strobe with that line's number. The block then does three things:
- It clears the pending request, but only for an edge line.
- It marks the line as in service, unless automatic end-of-interrupt is selected.
- When automatic end-of-interrupt is combined with rotation, it moves the rotation base to the line just after the acknowledged one.

A controller re-initialization pulse returns the request, in-service and rotation state to zero. The trigger selection survives it.

Top module: `intreq_capture`

## Requirements
- R1: After a synchronous reset, the request register, in-service register, rotation base and trigger-select register all read zero.
- R2: On an edge line (trigger bit 0), the request bit sets one clock after the input is sampled high following a sample low. An input held high does not set the request again after an acknowledge has cleared it.
- R3: On an edge line, a falling input leaves a pending request bit set and re-arms the line for its next rise.
- R4: On a level line (trigger bit 1), the request bit equals the input level sampled on the previous clock.
- R5: A trigger-select write stores the written byte ANDed with the parameter WR_MASK (default 8'hF8), visible on the read port one clock later. Without a write, the register holds its value.
- R6: An acknowledge of line n with automatic end-of-interrupt off sets in-service bit n and leaves the rotation base unchanged.
- R7: An acknowledge of line n clears request bit n when line n is edge-triggered. It leaves a level line's request untouched.
- R8: An acknowledge of line n with automatic end-of-interrupt on sets no in-service bit. With rotation also on, the rotation base becomes (n+1) mod 8; with rotation off, it is unchanged.
- R9: An acknowledge of an edge line in the same cycle as a new rise on that line leaves its request bit set.
- R10: A re-initialization pulse clears the request, in-service, rotation base and remembered levels on the next clock. The trigger-select register is kept.
- R11: With the acknowledge strobe low and no re-initialization, the in-service register and rotation base do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_req | input | 8 | Raw interrupt request inputs, one per line |
| trig_we | input | 1 | Trigger-select register write strobe |
| trig_wdata | input | 8 | Trigger-select write data (1 = level, 0 = edge) |
| trig_rdata | output | 8 | Trigger-select register contents |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Line number being acknowledged |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| rotate_aeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| reinit | input | 1 | Controller re-initialization pulse |
| req_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| rot_base | output | 3 | Rotation base (line with highest priority) |

## Verification
Directed sequences cover the cases that separate edge from level capture:
- an input held high across an acknowledge, which re-triggers only a level line;
- a falling edge while a request is pending;
- a new rise coinciding with its own acknowledge;
- an acknowledge of a level line.

The three combinations of automatic end-of-interrupt and rotation are tried on several lines, including the wrap from line 7 to line 0. This separates in-service marking from base rotation. Random input bytes, mixed with sparse trigger writes, acknowledges and re-initialization pulses, drive long runs with both trigger kinds present. These runs expose any mismatch against a bench model in which line kind and acknowledge interact.

// File: rtl/intreq_pkg.sv
`timescale 1ns/1ps
package intreq_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/intreq_line.sv
`timescale 1ns/1ps
module intreq_line
  import intreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reinit,
  input  logic       raw,
  input  trig_mode_e mode,
  input  logic       ack_hit,
  output logic       req
);
  logic last_q;
  logic rise;
  logic req_d;

  assign rise = raw & ~last_q;

  // A new rise wins over a simultaneous acknowledge.
  always_comb begin
    if (mode == TRIG_LEVEL) req_d = raw;
    else                    req_d = (req & ~ack_hit) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      last_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      last_q <= raw;
      req    <= req_d;
    end
  end
endmodule

// File: rtl/intreq_trig.sv
`timescale 1ns/1ps
module intreq_trig #(
  parameter int               LINES   = 8,
  parameter logic [LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (we) sel_q <= wdata & WR_MASK;
  end
endmodule

// File: rtl/intreq_ack.sv
`timescale 1ns/1ps
module intreq_ack #(
  parameter  int LINES = 8,
  localparam int IDW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reinit,
  input  logic             ack_valid,
  input  logic [IDW-1:0]   ack_line,
  input  logic             auto_eoi,
  input  logic             rotate_aeoi,
  output logic [LINES-1:0] ack_hit,
  output logic [LINES-1:0] isr_q,
  output logic [IDW-1:0]   rot_q
);
  localparam logic [IDW-1:0] LAST = IDW'(LINES - 1);

  logic [IDW-1:0] next_base;

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign ack_hit[g] = ack_valid && (ack_line == IDW'(g));
  end

  assign next_base = (ack_line == LAST) ? '0 : ack_line + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      isr_q <= '0;
      rot_q <= '0;
    end else if (ack_valid) begin
      if (!auto_eoi)        isr_q <= isr_q | ack_hit;
      else if (rotate_aeoi) rot_q <= next_base;
    end
  end
endmodule

// File: rtl/intreq_capture.sv
`timescale 1ns/1ps
module intreq_capture
  import intreq_pkg::*;
#(
  parameter  int               LINES   = 8,
  parameter  logic [LINES-1:0] WR_MASK = 8'hF8,
  localparam int               IDW     = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_req,
  input  logic             trig_we,
  input  logic [LINES-1:0] trig_wdata,
  output logic [LINES-1:0] trig_rdata,
  input  logic             ack_valid,
  input  logic [IDW-1:0]   ack_line,
  input  logic             auto_eoi,
  input  logic             rotate_aeoi,
  input  logic             reinit,
  output logic [LINES-1:0] req_q,
  output logic [LINES-1:0] isr_q,
  output logic [IDW-1:0]   rot_base
);
  logic [LINES-1:0] ack_hit;

  intreq_trig #(.LINES(LINES), .WR_MASK(WR_MASK)) u_trig (
    .clk   (clk),
    .rst   (rst),
    .we    (trig_we),
    .wdata (trig_wdata),
    .sel_q (trig_rdata)
  );

  intreq_ack #(.LINES(LINES)) u_ack (
    .clk         (clk),
    .rst         (rst),
    .reinit      (reinit),
    .ack_valid   (ack_valid),
    .ack_line    (ack_line),
    .auto_eoi    (auto_eoi),
    .rotate_aeoi (rotate_aeoi),
    .ack_hit     (ack_hit),
    .isr_q       (isr_q),
    .rot_q       (rot_base)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    intreq_line u_line (
      .clk     (clk),
      .rst     (rst),
      .reinit  (reinit),
      .raw     (raw_req[g]),
      .mode    (trig_mode_e'(trig_rdata[g])),
      .ack_hit (ack_hit[g]),
      .req     (req_q[g])
    );
  end
endmodule

// File: rtl/intreq_capture_chk.sv
`timescale 1ns/1ps
module intreq_capture_chk #(
  parameter  int               LINES   = 8,
  parameter  logic [LINES-1:0] WR_MASK = 8'hF8,
  localparam int               IDW     = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] raw_req,
  input logic             trig_we,
  input logic [LINES-1:0] trig_wdata,
  input logic [LINES-1:0] trig_rdata,
  input logic             ack_valid,
  input logic [IDW-1:0]   ack_line,
  input logic             auto_eoi,
  input logic             rotate_aeoi,
  input logic             reinit,
  input logic [LINES-1:0] req_q,
  input logic [LINES-1:0] isr_q,
  input logic [IDW-1:0]   rot_base
);
  logic [IDW-1:0] exp_base;
  assign exp_base = (ack_line == IDW'(LINES - 1)) ? '0 : ack_line + 1'b1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (req_q == '0 && isr_q == '0 && rot_base == '0 && trig_rdata == '0));

  assert_trig_write_R5: assert property (@(posedge clk) disable iff (rst)
    trig_we |=> trig_rdata == ($past(trig_wdata) & WR_MASK));

  assert_trig_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !trig_we |=> $stable(trig_rdata));

  assert_isr_mark_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !auto_eoi && !reinit) |=> isr_q[$past(ack_line)]);

  assert_rotate_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && auto_eoi && rotate_aeoi && !reinit) |=> rot_base == $past(exp_base));

  assert_aeoi_no_isr_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && auto_eoi && !reinit) |=> $stable(isr_q));

  assert_reinit_R10: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (req_q == '0 && isr_q == '0 && rot_base == '0));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!ack_valid && !reinit) |=> ($stable(isr_q) && $stable(rot_base)));

  for (genvar g = 0; g < LINES; g++) begin : g_lvl
    assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
      (trig_rdata[g] && !reinit) |=> req_q[g] == $past(raw_req[g]));
    assert_edge_rise_R2: assert property (@(posedge clk) disable iff (rst)
      (!trig_rdata[g] && !reinit && raw_req[g] && !$past(raw_req[g]) && !$past(reinit))
        |=> req_q[g]);
  end
endmodule

bind intreq_capture intreq_capture_chk #(.LINES(LINES), .WR_MASK(WR_MASK)) u_chk (.*);

// File: tb/intreq_capture_test.sv
`timescale 1ns/1ps
module intreq_capture_test;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] raw_req = '0;
  logic       trig_we = 1'b0;
  logic [7:0] trig_wdata = '0;
  logic [7:0] trig_rdata;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic       auto_eoi = 1'b0;
  logic       rotate_aeoi = 1'b0;
  logic       reinit = 1'b0;
  logic [7:0] req_q;
  logic [7:0] isr_q;
  logic [2:0] rot_base;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_req = '0, m_isr = '0, m_trig = '0, m_last = '0;
  logic [2:0] m_rot = '0;

  always #2.5 clk = ~clk;

  intreq_capture #(.LINES(8), .WR_MASK(MASK)) uut (
    .clk(clk), .rst(rst), .raw_req(raw_req), .trig_we(trig_we),
    .trig_wdata(trig_wdata), .trig_rdata(trig_rdata), .ack_valid(ack_valid),
    .ack_line(ack_line), .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi),
    .reinit(reinit), .req_q(req_q), .isr_q(isr_q), .rot_base(rot_base)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_req(input logic [7:0] cur, input logic [7:0] last,
                                          input logic [7:0] trig, input logic [7:0] raw,
                                          input logic av, input logic [2:0] al);
    logic [7:0] n;
    for (int i = 0; i < 8; i++) begin
      if (trig[i]) n[i] = raw[i];
      else begin
        n[i] = cur[i];
        if (av && al == 3'(i)) n[i] = 1'b0;
        if (raw[i] && !last[i]) n[i] = 1'b1;
      end
    end
    return n;
  endfunction

  task automatic step(input logic [7:0] raw, input logic we, input logic [7:0] wd,
                      input logic av, input logic [2:0] al, input logic ae,
                      input logic rr, input logic ri);
    @(negedge clk);
    raw_req = raw; trig_we = we; trig_wdata = wd; ack_valid = av;
    ack_line = al; auto_eoi = ae; rotate_aeoi = rr; reinit = ri;
    if (ri) begin
      m_req = '0; m_isr = '0; m_rot = '0; m_last = '0;
    end else begin
      m_req  = next_req(m_req, m_last, m_trig, raw, av, al);
      m_last = raw;
      if (av) begin
        if (!ae)     m_isr[al] = 1'b1;
        else if (rr) m_rot = al + 3'd1;
      end
    end
    if (we) m_trig = wd & MASK;
    @(posedge clk);
    #1;
    chk("R2 request register", req_q, m_req);
    chk("R6 in-service register", isr_q, m_isr);
    chk("R8 rotation base", {5'd0, rot_base}, {5'd0, m_rot});
    chk("R5 trigger select", trig_rdata, m_trig);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset req", req_q, 8'h00);
    chk("R1 reset isr", isr_q, 8'h00);
    chk("R1 reset rot", {5'd0, rot_base}, 8'h00);
    chk("R1 reset trig", trig_rdata, 8'h00);

    step(8'h00, 1, 8'hFF, 0, 0, 0, 0, 0);
    chk("R5 masked write", trig_rdata, 8'hF8);
    step(8'h00, 1, 8'h00, 0, 0, 0, 0, 0);

    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 rise sets", req_q, 8'h01);
    step(8'h01, 0, 0, 1, 3'd0, 0, 0, 0);
    chk("R7 edge ack clears", req_q, 8'h00);
    chk("R6 ack marks isr", isr_q, 8'h01);
    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 held high no retrigger", req_q, 8'h00);
    step(8'h00, 0, 0, 0, 0, 0, 0, 0);
    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 second rise", req_q, 8'h01);
    step(8'h03, 0, 0, 0, 0, 0, 0, 0);
    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 fall keeps request", req_q, 8'h03);

    step(8'h01, 1, 8'h08, 0, 0, 0, 0, 0);
    step(8'h09, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 level high", req_q, 8'h0B);
    step(8'h09, 0, 0, 1, 3'd3, 0, 0, 0);
    chk("R7 level ack keeps", req_q, 8'h0B);
    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 level low", req_q, 8'h03);

    step(8'h01, 0, 0, 1, 3'd5, 1, 1, 0);
    chk("R8 rotate", {5'd0, rot_base}, 8'h06);
    chk("R8 no isr", isr_q, 8'h09);
    step(8'h01, 0, 0, 1, 3'd7, 1, 1, 0);
    chk("R8 rotate wrap", {5'd0, rot_base}, 8'h00);
    step(8'h01, 0, 0, 1, 3'd4, 1, 0, 0);
    chk("R8 no rotate", {5'd0, rot_base}, 8'h00);

    step(8'h41, 0, 0, 0, 0, 0, 0, 0);
    step(8'h01, 0, 0, 0, 0, 0, 0, 0);
    step(8'h41, 0, 0, 1, 3'd6, 0, 0, 0);
    chk("R9 rise beats ack", req_q, 8'h43);
    step(8'h41, 0, 0, 0, 3'd2, 1, 1, 0);
    chk("R11 idle isr", isr_q, 8'h49);
    chk("R11 idle rot", {5'd0, rot_base}, 8'h00);

    step(8'h41, 0, 0, 1, 3'd1, 0, 0, 1);
    chk("R10 reinit req", req_q, 8'h00);
    chk("R10 reinit isr", isr_q, 8'h00);
    chk("R10 keeps trig", trig_rdata, 8'h08);

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      step(8'($urandom), ($urandom % 16) == 0, 8'($urandom),
           ($urandom % 3) == 0, 3'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 64) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule